// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block watches for a stalled program. Each tick from a slow on-chip oscillator advances a fixed divide-by-128 prescaler. Every prescaler wrap advances a binary postscaler. A 4-bit select code picks which postscaler bit ends the period, so a timeout arrives after 128 × 2^code oscillator ticks. Software keeps the timer from firing by issuing a clear strobe before that count is reached.

The timer can be started in two ways. A configuration-level enable forces it on. A software enable bit, bit 0 of a byte-wide control register, turns it on when the configuration enable is low. When neither is active, the counters are held at zero. The count also restarts from zero on a clear strobe, a sleep strobe, a clock-failure flag or a device reset.

An expiry during normal operation gives a one-cycle reset request. An expiry while the device sleeps gives a one-cycle wake-up request instead. A sticky timeout flag records that an expiry happened, and it survives device resets so that the cause can still be read afterwards.

Top module: `wdog_pscale_top`

## Requirements
- R1: With oscillator ticks on every clock and select code c (0..15), the reset or wake-up pulse is high in the cycle after the 128 × 2^c-th clock edge that follows the edge on which the count was cleared.
- R2: Only cycles with `osc_tick` high advance the count. With ticks on every other cycle, the code-0 timeout takes 255 or 256 clocks.
- R3: The timer runs when `cfg_en` is high or software enable bit 0 is 1. `cfg_en` high makes it run even when the bit is 0. When both are off, no reset or wake-up pulse is produced.
- R4: Each of `clr_stb`, `slp_stb`, `clk_fail` and `dev_rst`, when high for one clock, restarts the count from zero. The next timeout is then a full period after that edge.
- R5: An expiry with `asleep` high gives a `wake_req` pulse only. An expiry with `asleep` low gives a `rst_req` pulse only. Each pulse lasts exactly one cycle.
- R6: `to_flag` rises together with the pulse. It stays set through `dev_rst`. It is cleared by `clr_stb`, by `slp_stb` or by power-on reset.
- R7: A register write stores `reg_wdata[0]` as the software enable bit. `reg_rdata` shows that bit at position 0, and bits 7..1 always read 0.
- R8: Power-on reset (`por_n` low) is asynchronous. It clears the enable bit, the flag, both pulses and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dev_rst | input | 1 | Device reset, synchronous; clears the count only |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| cfg_en | input | 1 | Configuration-level enable; overrides software |
| clr_stb | input | 1 | Clear-watchdog strobe |
| slp_stb | input | 1 | Sleep-instruction strobe |
| clk_fail | input | 1 | Clock-failure flag |
| asleep | input | 1 | Device is in sleep mode |
| sel | input | 4 | Postscaler select code (ratio 2^sel) |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| rst_req | output | 1 | One-cycle reset request on awake expiry |
| wake_req | output | 1 | One-cycle wake-up request on sleeping expiry |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The bench measures the exact clock count to expiry for several select codes. A postscaler tap that is off by one bit would give half or double the period, and a prescaler compare that is off by one would make the count miss 128 × 2^c. It restarts a partly elapsed count with each clearing source in turn, so a source left out of the clear term shows up as an early pulse. The bench also checks the enable override, the sleep-versus-run routing, and that the flag persists across device reset. Swapped outputs, a software bit that `cfg_en` wrongly masks, or a flag lost on `dev_rst` each fail a named check.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic flag;
    } wdog_out_t;
endpackage

// File: rtl/wdog_enreg.sv
module wdog_enreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sw_en
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr) en_d = wdata[0];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign rdata = {{(DATA_W-1){1'b0}}, en_q};
    assign sw_en = en_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic tick,
    output logic base_tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = tick && !clear && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign base_tick = wrap;
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
    parameter int SEL_W     = 4,
    parameter int POST_BITS = 15
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clear,
    input  logic             base_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    logic [POST_BITS-1:0] cnt_d, cnt_q;
    logic [POST_BITS-1:0] mask;
    int                   sel_eff;

    always_comb begin
        sel_eff = (32'(sel) > POST_BITS) ? POST_BITS : 32'(sel);
        for (int i = 0; i < POST_BITS; i++) begin
            mask[i] = (i < sel_eff);
        end
        expire = base_tick && ((cnt_q & mask) == mask);
        cnt_d  = cnt_q;
        if (clear)          cnt_d = '0;
        else if (base_tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_pscale_top.sv
module wdog_pscale_top
    import wdog_pkg::*;
#(
    parameter int PRE_DIV   = 128,
    parameter int SEL_W     = 4,
    parameter int POST_BITS = 15,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              dev_rst,
    input  logic              osc_tick,
    input  logic              cfg_en,
    input  logic              clr_stb,
    input  logic              slp_stb,
    input  logic              clk_fail,
    input  logic              asleep,
    input  logic [SEL_W-1:0]  sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rst_req,
    output logic              wake_req,
    output logic              to_flag
);
    logic      sw_en, run, clear, base_tick, expire;
    wdog_out_t out_d, out_q;

    wdog_enreg #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .por_n(por_n), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .sw_en(sw_en)
    );

    assign run   = cfg_en | sw_en;
    assign clear = !run | clr_stb | slp_stb | clk_fail | dev_rst;

    wdog_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .por_n(por_n), .clear(clear), .tick(osc_tick),
        .base_tick(base_tick)
    );

    wdog_postscale #(.SEL_W(SEL_W), .POST_BITS(POST_BITS)) u_post (
        .clk(clk), .por_n(por_n), .clear(clear), .base_tick(base_tick),
        .sel(sel), .expire(expire)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rst_req  = expire && !asleep;
        out_d.wake_req = expire && asleep;
        if (clr_stb || slp_stb) out_d.flag = 1'b0;
        else if (expire)        out_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rst_req  = out_q.rst_req;
    assign wake_req = out_q.wake_req;
    assign to_flag  = out_q.flag;
endmodule

// File: rtl/wdog_pscale_chk.sv
module wdog_pscale_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              cfg_en,
    input logic              clr_stb,
    input logic              slp_stb,
    input logic              asleep,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rst_req,
    input logic              wake_req,
    input logic              to_flag
);
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !(rst_req && wake_req));
    a_r5_rst_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);
    a_r5_wake_single: assert property (@(posedge clk) disable iff (!por_n)
        wake_req |=> !wake_req);
    a_r5_rst_awake: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> !$past(asleep));
    a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!por_n)
        (rst_req || wake_req) |-> to_flag);
    a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!por_n)
        (clr_stb || slp_stb) |=> !to_flag);
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[DATA_W-1:1] == '0);
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_en && !reg_rdata[0]) |=> (!rst_req && !wake_req));
endmodule

bind wdog_pscale_top wdog_pscale_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .por_n(por_n), .cfg_en(cfg_en), .clr_stb(clr_stb),
    .slp_stb(slp_stb), .asleep(asleep), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
);

// File: tb/wdog_pscale_top_tb_top.sv
`timescale 1ns/1ps
module wdog_pscale_top_tb_top;
    logic       clk = 0;
    logic       por_n = 0, dev_rst = 0, osc_tick = 1, cfg_en = 0;
    logic       clr_stb = 0, slp_stb = 0, clk_fail = 0, asleep = 0;
    logic [3:0] sel = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       rst_req, wake_req, to_flag;
    logic       half_rate = 0;
    int         checks = 0, errors = 0, cycles = 0;

    always #5 clk = ~clk;

    always @(negedge clk) osc_tick <= half_rate ? ~osc_tick : 1'b1;

    wdog_pscale_top dut_i (
        .clk(clk), .por_n(por_n), .dev_rst(dev_rst), .osc_tick(osc_tick),
        .cfg_en(cfg_en), .clr_stb(clr_stb), .slp_stb(slp_stb),
        .clk_fail(clk_fail), .asleep(asleep), .sel(sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req),
        .wake_req(wake_req), .to_flag(to_flag)
    );

    // fields: sel, cfg_en, sw bit, asleep, expected clocks
    localparam logic [38:0] VECS [0:5] = '{
        {4'd0, 1'b1, 1'b0, 1'b0, 32'd128},
        {4'd1, 1'b0, 1'b1, 1'b0, 32'd256},
        {4'd2, 1'b1, 1'b1, 1'b1, 32'd512},
        {4'd4, 1'b0, 1'b1, 1'b1, 32'd2048},
        {4'd6, 1'b1, 1'b0, 1'b0, 32'd8192},
        {4'd7, 1'b0, 1'b1, 1'b1, 32'd16384}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic pulse_clr;
        @(negedge clk); clr_stb = 1;
        @(negedge clk); clr_stb = 0;
    endtask

    // counts clock edges until a pulse is seen (or limit)
    task automatic measure(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!rst_req && !wake_req && n < limit);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 rst_req at reset", rst_req, 0);
        check("R8 flag at reset", to_flag, 0);
        check("R7 rdata at reset", reg_rdata, 0);
        por_n = 1;
        @(negedge clk);

        foreach (VECS[i]) begin
            logic [38:0] v;
            v = VECS[i];
            sel = v[38:35]; cfg_en = v[34]; asleep = v[32];
            wr_reg({7'd0, v[33]});
            pulse_clr;
            measure(40000, n);
            check("R1 period", n, int'(v[31:0]));
            check("R5 rst_req routing", rst_req, v[32] ? 0 : 1);
            check("R5 wake_req routing", wake_req, v[32] ? 1 : 0);
            check("R6 flag set", to_flag, 1);
            @(negedge clk);
            check("R5 one cycle", rst_req | wake_req, 0);
        end

        // R6: flag held over dev_rst, cleared by clr_stb
        asleep = 0; sel = 0; cfg_en = 1;
        @(negedge clk); dev_rst = 1; @(negedge clk); dev_rst = 0;
        check("R6 flag kept over dev_rst", to_flag, 1);
        pulse_clr;
        check("R6 flag cleared by clr", to_flag, 0);

        // R4: each source restarts the count
        repeat (100) @(negedge clk);
        clk_fail = 1; @(negedge clk); clk_fail = 0;
        measure(1000, n); check("R4 clk_fail restart", n, 128);
        check("R6 flag set again", to_flag, 1);
        repeat (100) @(negedge clk);
        slp_stb = 1; @(negedge clk); slp_stb = 0;
        check("R6 flag cleared by slp", to_flag, 0);
        measure(1000, n); check("R4 slp_stb restart", n, 128);
        repeat (100) @(negedge clk);
        dev_rst = 1; @(negedge clk); dev_rst = 0;
        measure(1000, n); check("R4 dev_rst restart", n, 128);
        repeat (100) @(negedge clk);
        pulse_clr;
        measure(1000, n); check("R4 clr_stb restart", n, 128);

        // R3: both enables off gives no pulse
        cfg_en = 0; wr_reg(8'h00);
        pulse_clr;
        measure(400, n);
        check("R3 disabled silent", rst_req | wake_req, 0);
        // R3: cfg_en overrides a zero software bit
        cfg_en = 1; pulse_clr;
        measure(1000, n); check("R3 cfg override", n, 128);

        // R2: ticks on every other cycle
        half_rate = 1; pulse_clr;
        measure(1000, n);
        check("R2 half rate", (n == 255 || n == 256) ? 1 : 0, 1);
        half_rate = 0;

        // R7: upper bits read zero
        wr_reg(8'hFF);
        check("R7 readback ff", reg_rdata, 8'h01);
        wr_reg(8'hFE);
        check("R7 readback fe", reg_rdata, 8'h00);

        // R8: asynchronous power-on reset
        wr_reg(8'h01); pulse_clr; measure(1000, n);
        #2 por_n = 0; #1;
        check("R8 async clears enable", reg_rdata, 0);
        check("R8 async clears flag", to_flag, 0);
        @(negedge clk); por_n = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule